// File: doc/BRIEF.md
# Byte-Bus Access Unit for a 16-Bit Clear-on-Match Timer

This block joins an up-counter with two compare registers to a CPU that has an 8-bit data bus. A control bit selects the width. In narrow mode every byte register is a separate location that the CPU reads and writes directly. In wide mode the counter and both compare registers become 16-bit values. One staging byte, shared by all of them, makes each 16-bit transfer atomic. Software writes the high byte first, and that write only fills the staging byte. The low-byte write then commits both bytes on one clock edge. For reads, software reads the low byte first. That read latches the matching high byte into the staging byte, and the later high-byte read returns it.

A second control bit turns the two compare locations into a capture view. Their low-byte reads then stage the high byte in the same way as counter reads. Without that bit, compare registers are always read directly.

The counter advances only on cycles where the prescale enable input is high. Each cycle the counter performs one operation:
- HOLD: no enable pulse, so the counter keeps its value.
- LOAD: a CPU low-byte write replaces the count.
- STEP: the counter adds one.
- WRAP: the counter is at TOP and goes back to zero.

TOP is compare register A. A sticky match flag is set when a STEP or WRAP leaves the counter equal to TOP.

Top module: `tmr16_regif`

## Requirements
- R1: Register map on the 3-bit address: 0 counter low, 1 counter high, 2 compare A low, 3 compare A high, 4 compare B low, 5 compare B high, 6 control (bit 0 wide mode, bit 1 capture view), 7 flags (bit 0 match). After reset every location reads 0. Read data is valid in the same cycle as the read strobe.
- R2: In wide mode, a write to a high-byte address changes only the staging byte. The next low-byte write loads {staging byte, written byte} into the 16-bit register on one edge.
- R3: In wide mode, reading the counter low byte returns it and stages the counter high byte. A counter high-byte read returns the staging byte, even if the counter has ticked since.
- R4: In wide mode with the capture view off, compare reads return the register bytes directly and leave the staging byte unchanged.
- R5: In wide mode with the capture view on, a compare low-byte read stages that register's high byte, and a compare high-byte read returns the staging byte.
- R6: The staging byte is common to all registers. A byte staged through one register's high address is used by a low-byte write to another register.
- R7: In narrow mode, each byte is written and read directly, and the staging byte is neither loaded nor used.
- R8: The counter changes only on an enable pulse or a CPU write. Each pulse adds one when the counter is below TOP.
- R9: On a pulse at TOP the counter returns to zero. The match flag (flags bit 0, also the cmp_flag pin) sets in the cycle the counter reaches TOP.
- R10: A CPU low-byte counter write in the same cycle as an enable pulse wins over STEP or WRAP.
- R11: Writing 1 to flags bit 0 clears the match flag. Writing 0 has no effect. A hardware set in the same cycle wins over the clear.
- R12: In narrow mode only the counter low byte counts, with TOP taken from the compare A low byte. The counter high byte is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescale enable pulse; one counter step per high cycle |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; zero when bus_rd is low |
| cmp_flag | output | 1 | Sticky match flag |

## Verification
A corrupted staging byte stays hidden until the next high-byte read in wide mode. That read then returns the wrong value in the same cycle as its strobe. The vectors therefore put a high read straight after every operation that should, or should not, touch the staging byte. A wrong count or a wrong HOLD/LOAD/STEP/WRAP choice shows on the first low-byte read after the faulty edge. A missed or stale flag update shows on cmp_flag one cycle after the edge that should have set or cleared it.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
    localparam int ADDR_W     = 3;
    localparam int CTRL_WIDE  = 0;
    localparam int CTRL_CAPV  = 1;
    localparam int FLAG_MATCH = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT_LO  = 3'd0,
        A_CNT_HI  = 3'd1,
        A_CMPA_LO = 3'd2,
        A_CMPA_HI = 3'd3,
        A_CMPB_LO = 3'd4,
        A_CMPB_HI = 3'd5,
        A_CTRL    = 3'd6,
        A_FLAG    = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_STEP,
        OP_WRAP
    } cnt_op_e;
endpackage

// File: rtl/tmr16_byteport.sv
`timescale 1ns/1ps
module tmr16_byteport
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [2*DATA_W-1:0]   cnt_q,
    input  logic                  flag_q,
    output logic                  wide,
    output logic [2*DATA_W-1:0]   top_val,
    output logic [1:0]            cnt_wr_be,
    output logic [2*DATA_W-1:0]   cnt_wr_val,
    output logic                  flag_clr
);
    localparam int WORD_W = 2 * DATA_W;
    localparam int NCMP   = 2;

    reg_addr_e                    addr;
    logic [1:0]                   ctrl_q;
    logic                         capv;
    logic [DATA_W-1:0]            temp_q, temp_d, rd_mux;
    logic [NCMP-1:0][WORD_W-1:0]  cmp_w;
    logic [WORD_W-1:0]            cmp_sel;
    logic                         hi_stage;

    assign addr    = reg_addr_e'(bus_addr);
    assign wide    = ctrl_q[CTRL_WIDE];
    assign capv    = ctrl_q[CTRL_CAPV];
    assign cmp_sel = cmp_w[bus_addr[2]];
    assign top_val = cmp_w[0];

    // Compare registers: one slice per register, addresses two apart.
    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(int'(A_CMPA_LO) + 2 * g);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(int'(A_CMPA_LO) + 2 * g + 1);
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (bus_wr && bus_addr == LO_A) begin
                q <= wide ? {temp_q, bus_wdata} : {q[WORD_W-1:DATA_W], bus_wdata};
            end else if (bus_wr && !wide && bus_addr == HI_A) begin
                q[WORD_W-1:DATA_W] <= bus_wdata;
            end
        end
        assign cmp_w[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && addr == A_CTRL) begin
            ctrl_q <= bus_wdata[1:0];
        end
    end

    assign flag_clr   = bus_wr && addr == A_FLAG && bus_wdata[FLAG_MATCH];
    assign cnt_wr_val = {(wide ? temp_q : bus_wdata), bus_wdata};

    always_comb begin
        cnt_wr_be = 2'b00;
        if (bus_wr) begin
            if (addr == A_CNT_LO) begin
                cnt_wr_be = wide ? 2'b11 : 2'b01;
            end else if (addr == A_CNT_HI && !wide) begin
                cnt_wr_be = 2'b10;
            end
        end
    end

    // Shared staging byte: writes take priority over read-side loads.
    assign hi_stage = wide && (addr == A_CNT_HI || addr == A_CMPA_HI || addr == A_CMPB_HI);

    always_comb begin
        temp_d = temp_q;
        if (bus_wr) begin
            if (hi_stage) begin
                temp_d = bus_wdata;
            end
        end else if (bus_rd && wide) begin
            if (addr == A_CNT_LO) begin
                temp_d = cnt_q[WORD_W-1:DATA_W];
            end else if (capv && (addr == A_CMPA_LO || addr == A_CMPB_LO)) begin
                temp_d = cmp_sel[WORD_W-1:DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else begin
            temp_q <= temp_d;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            A_CNT_LO:             rd_mux = cnt_q[DATA_W-1:0];
            A_CNT_HI:             rd_mux = wide ? temp_q : cnt_q[WORD_W-1:DATA_W];
            A_CMPA_LO, A_CMPB_LO: rd_mux = cmp_sel[DATA_W-1:0];
            A_CMPA_HI, A_CMPB_HI: rd_mux = (wide && capv) ? temp_q : cmp_sel[WORD_W-1:DATA_W];
            A_CTRL:               rd_mux = DATA_W'(ctrl_q);
            A_FLAG:               rd_mux = DATA_W'(flag_q);
            default:              rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;

    // High-byte write in wide mode must leave compare contents alone (R2).
    assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wide && bus_addr == A_CMPA_HI) |=> $stable(cmp_w));

    // Counter low read stages the high byte present at that edge (R3).
    assert_lo_read_stages_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && wide && bus_addr == A_CNT_LO)
            |=> (temp_q == $past(cnt_q[WORD_W-1:DATA_W])));

    // Narrow mode never touches the staging byte (R7).
    assert_narrow_temp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide) |=> $stable(temp_q));
endmodule

// File: rtl/tmr16_ctc_core.sv
`timescale 1ns/1ps
module tmr16_ctc_core
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                wide,
    input  logic [2*DATA_W-1:0] top_val,
    input  logic [1:0]          cnt_wr_be,
    input  logic [2*DATA_W-1:0] cnt_wr_val,
    input  logic                flag_clr,
    output logic [2*DATA_W-1:0] cnt_q,
    output logic                flag_q
);
    localparam int WORD_W = 2 * DATA_W;

    cnt_op_e           op;
    logic              at_top, flag_set, flag_d;
    logic [WORD_W-1:0] cnt_d;

    function automatic logic hits(input logic w, input logic [WORD_W-1:0] c,
                                  input logic [WORD_W-1:0] t);
        return w ? (c == t) : (c[DATA_W-1:0] == t[DATA_W-1:0]);
    endfunction

    assign at_top = hits(wide, cnt_q, top_val);

    // Operation select: a CPU load beats any tick.
    always_comb begin
        if (cnt_wr_be[0])  op = OP_LOAD;
        else if (!tick_en) op = OP_HOLD;
        else if (at_top)   op = OP_WRAP;
        else               op = OP_STEP;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (op)
            OP_HOLD: cnt_d = cnt_q;
            OP_LOAD: cnt_d[DATA_W-1:0] = cnt_wr_val[DATA_W-1:0];
            OP_STEP: begin
                if (wide) cnt_d = cnt_q + WORD_W'(1);
                else      cnt_d[DATA_W-1:0] = cnt_q[DATA_W-1:0] + DATA_W'(1);
            end
            OP_WRAP: begin
                if (wide) cnt_d = '0;
                else      cnt_d[DATA_W-1:0] = '0;
            end
            default: cnt_d = cnt_q;
        endcase
        if (cnt_wr_be[1]) begin
            cnt_d[WORD_W-1:DATA_W] = cnt_wr_val[WORD_W-1:DATA_W];
        end
    end

    assign flag_set = (op == OP_STEP || op == OP_WRAP) && hits(wide, cnt_d, top_val);
    assign flag_d   = flag_set | (flag_q & ~flag_clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && cnt_wr_be == 2'b00) |=> $stable(cnt_q));

    assert_wrap_to_bottom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr_be[0] && at_top) |=> (cnt_q[DATA_W-1:0] == '0));

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_be[0] |=> (cnt_q[DATA_W-1:0] == $past(cnt_wr_val[DATA_W-1:0])));

    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag_q);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/tmr16_regif.sv
`timescale 1ns/1ps
module tmr16_regif
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmp_flag
);
    localparam int WORD_W = 2 * DATA_W;

    logic              wide, flag_clr;
    logic [1:0]        cnt_wr_be;
    logic [WORD_W-1:0] top_val, cnt_wr_val, cnt_q;

    tmr16_byteport #(.DATA_W(DATA_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_q      (cnt_q),
        .flag_q     (cmp_flag),
        .wide       (wide),
        .top_val    (top_val),
        .cnt_wr_be  (cnt_wr_be),
        .cnt_wr_val (cnt_wr_val),
        .flag_clr   (flag_clr)
    );

    tmr16_ctc_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wide       (wide),
        .top_val    (top_val),
        .cnt_wr_be  (cnt_wr_be),
        .cnt_wr_val (cnt_wr_val),
        .flag_clr   (flag_clr),
        .cnt_q      (cnt_q),
        .flag_q     (cmp_flag)
    );
endmodule

// File: tb/tb_tmr16_regif.sv
`timescale 1ns/1ps
module tb_tmr16_regif;
    logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    wire  [7:0] bus_rdata;
    wire        cmp_flag;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    tmr16_regif #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_flag(cmp_flag)
    );

    localparam logic [2:0] O_ID = 3'd0, O_RD = 3'd1, O_WR = 3'd2, O_TK = 3'd3, O_TW = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        '{O_WR, 3'd3, 8'hAB, 8'h00, 4'd0},
        '{O_RD, 3'd3, 8'h00, 8'hAB, 4'd7},   // R7 narrow direct high
        '{O_WR, 3'd2, 8'hCD, 8'h00, 4'd0},
        '{O_RD, 3'd2, 8'h00, 8'hCD, 4'd7},   // R7
        '{O_RD, 3'd3, 8'h00, 8'hAB, 4'd7},   // R7
        '{O_WR, 3'd6, 8'h01, 8'h00, 4'd0},
        '{O_RD, 3'd6, 8'h00, 8'h01, 4'd1},   // R1 control readback
        '{O_RD, 3'd1, 8'h00, 8'h00, 4'd7},   // R7 staging untouched
        '{O_WR, 3'd3, 8'h12, 8'h00, 4'd0},
        '{O_RD, 3'd3, 8'h00, 8'hAB, 4'd2},   // R2 high write only staged
        '{O_WR, 3'd2, 8'h34, 8'h00, 4'd0},
        '{O_RD, 3'd3, 8'h00, 8'h12, 4'd2},   // R2
        '{O_RD, 3'd2, 8'h00, 8'h34, 4'd2},   // R2
        '{O_WR, 3'd1, 8'h56, 8'h00, 4'd0},
        '{O_WR, 3'd0, 8'h78, 8'h00, 4'd0},
        '{O_RD, 3'd3, 8'h00, 8'h12, 4'd4},   // R4 direct, not staging
        '{O_RD, 3'd0, 8'h00, 8'h78, 4'd2},   // R2 counter load
        '{O_WR, 3'd1, 8'h00, 8'h00, 4'd0},
        '{O_WR, 3'd0, 8'hFF, 8'h00, 4'd0},
        '{O_RD, 3'd0, 8'h00, 8'hFF, 4'd3},   // R3
        '{O_TK, 3'd0, 8'h00, 8'h00, 4'd0},
        '{O_RD, 3'd1, 8'h00, 8'h00, 4'd3},   // R3 stale staged byte
        '{O_RD, 3'd0, 8'h00, 8'h00, 4'd3},   // R3
        '{O_RD, 3'd1, 8'h00, 8'h01, 4'd3},   // R3
        '{O_WR, 3'd1, 8'h9A, 8'h00, 4'd0},
        '{O_WR, 3'd4, 8'hBC, 8'h00, 4'd0},
        '{O_RD, 3'd5, 8'h00, 8'h9A, 4'd6},   // R6 shared staging
        '{O_RD, 3'd4, 8'h00, 8'hBC, 4'd6},   // R6
        '{O_RD, 3'd1, 8'h00, 8'h9A, 4'd4},   // R4 compare reads kept staging
        '{O_RD, 3'd0, 8'h00, 8'h00, 4'd6},   // R6 counter not written
        '{O_RD, 3'd1, 8'h00, 8'h01, 4'd6},   // R6
        '{O_WR, 3'd6, 8'h03, 8'h00, 4'd0},
        '{O_RD, 3'd6, 8'h00, 8'h03, 4'd5},   // R5
        '{O_RD, 3'd5, 8'h00, 8'h01, 4'd5},   // R5 high via staging
        '{O_RD, 3'd4, 8'h00, 8'hBC, 4'd5},   // R5
        '{O_RD, 3'd5, 8'h00, 8'h9A, 4'd5},   // R5
        '{O_RD, 3'd2, 8'h00, 8'h34, 4'd5},   // R5
        '{O_RD, 3'd3, 8'h00, 8'h12, 4'd5},   // R5
        '{O_WR, 3'd6, 8'h01, 8'h00, 4'd0},
        '{O_RD, 3'd7, 8'h00, 8'h00, 4'd9}    // R9 no match so far
    };

    task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic op(input logic [2:0] kind, input logic [2:0] a, input logic [7:0] d,
                      output logic [7:0] r);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = (kind == O_WR) || (kind == O_TW);
        bus_rd    = (kind == O_RD);
        tick_en   = (kind == O_TK) || (kind == O_TW);
        #1 r = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr  = 1'b0;
        bus_rd  = 1'b0;
        tick_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] r;
        op(O_WR, a, d, r);
    endtask

    task automatic tk();
        logic [7:0] r;
        op(O_TK, 3'd0, 8'h00, r);
    endtask

    task automatic rdc(input logic [2:0] a, input logic [7:0] exp, input int req);
        logic [7:0] r;
        op(O_RD, a, 8'h00, r);
        chk(req, r, exp);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every location zero after reset
        for (int a = 0; a < 8; a++) rdc(3'(a), 8'h00, 1);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i].op, VEC[i].addr, VEC[i].data, r);
            if (VEC[i].op == O_RD) chk(int'(VEC[i].req), r, VEC[i].exp);
        end

        // R9: wide CTC with TOP = 3
        wr(3'd3, 8'h00); wr(3'd2, 8'h03);
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        tk(); tk(); tk();
        rdc(3'd7, 8'h01, 9);
        @(negedge clk) chk(9, {7'b0, cmp_flag}, 8'h01);   // R9 flag pin
        rdc(3'd0, 8'h03, 9);
        tk();
        rdc(3'd0, 8'h00, 9);                             // R9 back to bottom
        // R11: sticky flag, write-0 ignored, write-1 clears
        rdc(3'd7, 8'h01, 11);
        wr(3'd7, 8'h00);
        rdc(3'd7, 8'h01, 11);
        wr(3'd7, 8'h01);
        rdc(3'd7, 8'h00, 11);
        tk(); tk();
        rdc(3'd7, 8'h00, 9);
        op(O_TW, 3'd7, 8'h01, r);                        // set and clear together
        rdc(3'd7, 8'h01, 11);
        // R10: load beats a wrap-due tick
        wr(3'd1, 8'h00);
        op(O_TW, 3'd0, 8'h10, r);
        rdc(3'd0, 8'h10, 10);
        rdc(3'd1, 8'h00, 10);
        // R8: hold without pulses, step with one
        repeat (4) op(O_ID, 3'd0, 8'h00, r);
        rdc(3'd0, 8'h10, 8);
        tk();
        rdc(3'd0, 8'h11, 8);

        // R12: narrow counting on the low byte only
        wr(3'd7, 8'h01);
        wr(3'd6, 8'h00);
        wr(3'd1, 8'h77); wr(3'd0, 8'h00); wr(3'd2, 8'h02);
        tk(); tk();
        rdc(3'd7, 8'h01, 12);
        tk();
        rdc(3'd0, 8'h00, 12);
        rdc(3'd1, 8'h77, 12);

        // R1: reset mid-run returns everything to zero
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rdc(3'(a), 8'h00, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule